// File: doc/BRIEF.md
# Tag-Based Register Hazard Tracker

This block is the issue-stage interlock of an in-order pipeline. Each instruction it lets through is handed a small tag out of a pool of four. When the instruction names a destination register, the tracker marks that register pending and remembers the tag that will produce its next value. A later instruction that reads a pending register is held until the writeback port reports that tag. The value must really be written to the register file; there is no forwarding. The instruction may issue in the same cycle the matching writeback appears, because the register file takes the value on that edge.

The block also keeps a rule on which units may have work in flight. One unit, chosen by a parameter, is pipelined. More instructions for that unit may issue while earlier ones for it are still outstanding. An instruction for any other unit issues only when nothing at all is in flight. Once it is in flight, nothing else issues until it completes. A flush input drops every pending mark and frees every tag in one cycle. A small state machine handles the rule. Its states are `ST_IDLE` (nothing in flight), `ST_PIPE` (one or more operations outstanding on the pipelined unit) and `ST_SINGLE` (one operation outstanding on an unpipelined unit). Its transitions are:

- `ST_IDLE`→`ST_PIPE` on a grant to the pipelined unit.
- `ST_IDLE`→`ST_SINGLE` on a grant to any other unit.
- `ST_PIPE`→`ST_IDLE` when the last outstanding tag retires with no grant in that cycle.
- `ST_SINGLE`→`ST_IDLE` when its tag retires.
- Any state→`ST_IDLE` on flush.

Top module: `hazard_tracker`

## Requirements
- R1: After reset no register is pending, all four tags are free and the state is idle. An issue request naming any source registers is granted at once with tag 0, and the grant output is low whenever the request is low.
- R2: Every granted instruction receives, on `iss_tag` in the grant cycle, the lowest-numbered tag that was free before that cycle. A tag that was not free is never handed out.
- R3: A request whose enabled source register is pending is stalled. It is granted in the first cycle in which `wb_valid` is high with `wb_tag` equal to that register's recorded tag, or later.
- R4: A writeback clears a register's pending mark only if its tag matches the tag recorded for that register. After a newer writer has claimed the register, the older writer's writeback leaves it pending.
- R5: While all four tags are in use, every request stalls. A tag freed by a writeback can be granted from the following cycle.
- R6: Requests for the pipelined unit (unit code `PIPE_UNIT`, 1 by default) are granted back to back while earlier operations for that unit are still outstanding.
- R7: A request for any unit code other than `PIPE_UNIT` is granted only when no tag is in use. While such an instruction is outstanding, every request stalls.
- R8: In a cycle with `flush` high, no request is granted. From the next cycle, all pending marks and all tags are cleared.
- R9: A writeback whose tag is not currently in use has no effect on pending marks, tags or the unit rule.
- R10: When, in one cycle, a writeback retires the tag recorded for register r and a granted instruction names r as its destination, r stays pending on the new tag.
- R11: A source whose enable bit is low is not checked for hazards, whatever register number it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all pending marks and free all tags |
| iss_valid | input | 1 | Issue request present |
| iss_unit | input | UNIT_W | Execution unit targeted by the request |
| iss_rd_en | input | 1 | Request writes a destination register |
| iss_rd | input | REG_W | Destination register number |
| iss_ra_en | input | 1 | First source register is read |
| iss_ra | input | REG_W | First source register number |
| iss_rb_en | input | 1 | Second source register is read |
| iss_rb | input | REG_W | Second source register number |
| iss_grant | output | 1 | Request issues this cycle |
| iss_stall | output | 1 | Request present but held |
| iss_tag | output | TAG_W | Tag given to the granted instruction |
| wb_valid | input | 1 | A completion is reported |
| wb_tag | input | TAG_W | Tag of the completing instruction |

## Verification
Two functions can collide in one cycle: a writeback that retires a register's recorded tag and a new issue that names the same register as its destination. The same goes for a writeback that frees a tag while the pool is full and a request waiting for that tag. Directed scenarios drive the writeback and the request in the same cycle. A following read of the register must still stall, so the new writer is seen to win. A request made in the cycle of the freeing writeback must stall, and it must be granted the freed tag in the next cycle. Same-cycle writeback and read of a pending source is also provoked, and it must be granted in that cycle.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PIPE   = 2'd1,
        ST_SINGLE = 2'd2
    } iss_state_e;

endpackage

// File: rtl/hz_tag_pool.sv
module hz_tag_pool #(
    parameter int NTAG  = 4,
    parameter int TAG_W = $clog2(NTAG),
    parameter int CNT_W = $clog2(NTAG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc,
    input  logic             wb_valid,
    input  logic [TAG_W-1:0] wb_tag,
    output logic [TAG_W-1:0] alloc_tag,
    output logic             tag_avail,
    output logic             retire,
    output logic [CNT_W-1:0] busy_cnt
);

    logic [NTAG-1:0] busy_q;

    // lowest free tag wins
    always_comb begin
        alloc_tag = '0;
        tag_avail = 1'b0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                alloc_tag = i[TAG_W-1:0];
                tag_avail = 1'b1;
            end
        end
    end

    always_comb begin
        busy_cnt = '0;
        for (int i = 0; i < NTAG; i++) begin
            busy_cnt = busy_cnt + CNT_W'(busy_q[i]);
        end
    end

    assign retire = wb_valid & busy_q[wb_tag];

    genvar g;
    generate
        for (g = 0; g < NTAG; g++) begin : g_tag
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    busy_q[g] <= 1'b0;
                end else if (alloc && alloc_tag == g[TAG_W-1:0]) begin
                    busy_q[g] <= 1'b1;
                end else if (retire && wb_tag == g[TAG_W-1:0]) begin
                    busy_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
    parameter int NREG  = 32,
    parameter int REG_W = $clog2(NREG),
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_reg,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             retire,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic             ra_en,
    input  logic [REG_W-1:0] ra,
    input  logic             rb_en,
    input  logic [REG_W-1:0] rb,
    output logic             hazard
);

    logic [NREG-1:0]  pend_q;
    logic [TAG_W-1:0] tag_q [NREG];

    logic ra_block;
    logic rb_block;

    // a source blocks while pending unless its producer writes back now
    always_comb begin
        ra_block = ra_en && pend_q[ra] && !(retire && tag_q[ra] == wb_tag);
        rb_block = rb_en && pend_q[rb] && !(retire && tag_q[rb] == wb_tag);
        hazard   = ra_block || rb_block;
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            logic hit_set;
            logic hit_clr;
            assign hit_set = set_en && set_reg == g[REG_W-1:0];
            assign hit_clr = retire && pend_q[g] && tag_q[g] == wb_tag;

            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    pend_q[g] <= 1'b0;
                    tag_q[g]  <= '0;
                end else if (hit_set) begin
                    // newest writer takes over, even against a same-cycle clear
                    pend_q[g] <= 1'b1;
                    tag_q[g]  <= set_tag;
                end else if (hit_clr) begin
                    pend_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hz_issue_ctl.sv
module hz_issue_ctl
    import hazard_pkg::*;
#(
    parameter int UNIT_W    = 2,
    parameter int PIPE_UNIT = 1,
    parameter int CNT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic [UNIT_W-1:0] iss_unit,
    input  logic              src_hazard,
    input  logic              tag_avail,
    input  logic              retire,
    input  logic [CNT_W-1:0]  busy_cnt,
    output logic              grant
);

    localparam logic [UNIT_W-1:0] PIPE_CODE = UNIT_W'(PIPE_UNIT);
    localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);

    iss_state_e state_q;
    iss_state_e state_d;
    logic       unit_ok;
    logic       to_pipe;

    assign to_pipe = (iss_unit == PIPE_CODE);

    // output process
    always_comb begin
        unit_ok = 1'b0;
        unique case (state_q)
            ST_IDLE:   unit_ok = 1'b1;
            ST_PIPE:   unit_ok = to_pipe;
            ST_SINGLE: unit_ok = 1'b0;
            default:   unit_ok = 1'b0;
        endcase
        grant = iss_valid && !flush && unit_ok && tag_avail && !src_hazard;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (grant) state_d = to_pipe ? ST_PIPE : ST_SINGLE;
                end
                ST_PIPE: begin
                    if (!grant && retire && busy_cnt == ONE) state_d = ST_IDLE;
                end
                ST_SINGLE: begin
                    if (retire) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/hazard_tracker.sv
module hazard_tracker #(
    parameter int NREG      = 32,
    parameter int NTAG      = 4,
    parameter int NUNIT     = 4,
    parameter int PIPE_UNIT = 1,
    parameter int REG_W     = $clog2(NREG),
    parameter int TAG_W     = $clog2(NTAG),
    parameter int UNIT_W    = $clog2(NUNIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic [UNIT_W-1:0] iss_unit,
    input  logic              iss_rd_en,
    input  logic [REG_W-1:0]  iss_rd,
    input  logic              iss_ra_en,
    input  logic [REG_W-1:0]  iss_ra,
    input  logic              iss_rb_en,
    input  logic [REG_W-1:0]  iss_rb,
    output logic              iss_grant,
    output logic              iss_stall,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag
);

    localparam int CNT_W = $clog2(NTAG + 1);

    logic             tag_avail;
    logic             retire;
    logic [CNT_W-1:0] busy_cnt;
    logic             src_hazard;

    hz_tag_pool #(.NTAG(NTAG), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .alloc     (iss_grant),
        .wb_valid  (wb_valid),
        .wb_tag    (wb_tag),
        .alloc_tag (iss_tag),
        .tag_avail (tag_avail),
        .retire    (retire),
        .busy_cnt  (busy_cnt)
    );

    hz_scoreboard #(.NREG(NREG), .REG_W(REG_W), .TAG_W(TAG_W)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .set_en  (iss_grant && iss_rd_en),
        .set_reg (iss_rd),
        .set_tag (iss_tag),
        .retire  (retire),
        .wb_tag  (wb_tag),
        .ra_en   (iss_ra_en),
        .ra      (iss_ra),
        .rb_en   (iss_rb_en),
        .rb      (iss_rb),
        .hazard  (src_hazard)
    );

    hz_issue_ctl #(.UNIT_W(UNIT_W), .PIPE_UNIT(PIPE_UNIT), .CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .iss_valid  (iss_valid),
        .iss_unit   (iss_unit),
        .src_hazard (src_hazard),
        .tag_avail  (tag_avail),
        .retire     (retire),
        .busy_cnt   (busy_cnt),
        .grant      (iss_grant)
    );

    assign iss_stall = iss_valid && !iss_grant;

endmodule

// File: rtl/hazard_tracker_chk.sv
module hazard_tracker_chk #(
    parameter int NTAG      = 4,
    parameter int PIPE_UNIT = 1,
    parameter int TAG_W     = 2,
    parameter int UNIT_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              iss_valid,
    input logic [UNIT_W-1:0] iss_unit,
    input logic              iss_grant,
    input logic [TAG_W-1:0]  iss_tag,
    input logic              wb_valid,
    input logic [TAG_W-1:0]  wb_tag
);

    // tags in use, rebuilt from the ports alone
    logic [NTAG-1:0] sh_busy;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            sh_busy <= '0;
        end else begin
            for (int i = 0; i < NTAG; i++) begin
                if (iss_grant && iss_tag == i[TAG_W-1:0])    sh_busy[i] <= 1'b1;
                else if (wb_valid && wb_tag == i[TAG_W-1:0]) sh_busy[i] <= 1'b0;
            end
        end
    end

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |-> iss_valid); // R1
    AST_FRESH_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        iss_grant |-> !sh_busy[iss_tag]); // R2
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (&sh_busy) |-> !iss_grant); // R5
    AST_PIPE_ONLY_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_grant && sh_busy != '0) |-> iss_unit == UNIT_W'(PIPE_UNIT)); // R6
    AST_SOLO_UNPIPED: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_grant && iss_unit != UNIT_W'(PIPE_UNIT)) |-> sh_busy == '0); // R7
    AST_NO_GRANT_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_grant); // R8

endmodule

bind hazard_tracker hazard_tracker_chk #(
    .NTAG(NTAG), .PIPE_UNIT(PIPE_UNIT), .TAG_W(TAG_W), .UNIT_W(UNIT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .iss_valid (iss_valid),
    .iss_unit  (iss_unit),
    .iss_grant (iss_grant),
    .iss_tag   (iss_tag),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag)
);

// File: tb/hazard_tracker_tb.sv
module hazard_tracker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W  = 5;
    localparam int TAG_W  = 2;
    localparam int UNIT_W = 2;
    localparam logic [UNIT_W-1:0] UP = 2'd1; // pipelined unit
    localparam logic [UNIT_W-1:0] U0 = 2'd0;
    localparam logic [UNIT_W-1:0] U2 = 2'd2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              flush;
    logic              iss_valid;
    logic [UNIT_W-1:0] iss_unit;
    logic              iss_rd_en, iss_ra_en, iss_rb_en;
    logic [REG_W-1:0]  iss_rd, iss_ra, iss_rb;
    logic              iss_grant, iss_stall;
    logic [TAG_W-1:0]  iss_tag;
    logic              wb_valid;
    logic [TAG_W-1:0]  wb_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .iss_valid(iss_valid), .iss_unit(iss_unit),
        .iss_rd_en(iss_rd_en), .iss_rd(iss_rd),
        .iss_ra_en(iss_ra_en), .iss_ra(iss_ra),
        .iss_rb_en(iss_rb_en), .iss_rb(iss_rb),
        .iss_grant(iss_grant), .iss_stall(iss_stall), .iss_tag(iss_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag)
    );

    task automatic chk(input string req, input logic exp_g, input logic chk_tag,
                       input logic [TAG_W-1:0] exp_t);
        checks++;
        if (iss_grant !== exp_g || iss_stall !== (iss_valid && !exp_g) ||
            (chk_tag && exp_g && iss_tag !== exp_t)) begin
            errors++;
            $display("FAIL %s: grant=%0b stall=%0b tag=%0d expected grant=%0b tag=%0d",
                     req, iss_grant, iss_stall, iss_tag, exp_g, exp_t);
        end
    endtask

    // one cycle: drive after the falling edge, sample, then let the rising edge pass
    task automatic step(input logic v, input logic [UNIT_W-1:0] u,
                        input logic rde, input int rd,
                        input logic rae, input int ra,
                        input logic rbe, input int rb,
                        input logic wbv, input int wbt, input logic fl,
                        input string req, input logic exp_g,
                        input logic chk_tag, input int exp_t);
        @(negedge clk);
        iss_valid = v;   iss_unit = u;
        iss_rd_en = rde; iss_rd = REG_W'(rd);
        iss_ra_en = rae; iss_ra = REG_W'(ra);
        iss_rb_en = rbe; iss_rb = REG_W'(rb);
        wb_valid  = wbv; wb_tag = TAG_W'(wbt);
        flush     = fl;
        #1;
        chk(req, exp_g, chk_tag, TAG_W'(exp_t));
        @(posedge clk);
    endtask

    task automatic idle_wb(input int t);
        step(0, U0, 0, 0, 0, 0, 0, 0, 1, t, 0, "drain", 0, 0, 0);
    endtask

    task automatic do_flush();
        step(1, U0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 no grant in flush cycle", 0, 0, 0);
    endtask

    task automatic t_reset_single();
        // R1: idle, nothing pending after reset
        step(0, U0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 no grant without request", 0, 0, 0);
        step(1, U0, 1, 3, 1, 5, 1, 6, 0, 0, 0, "R1 first issue tag 0", 1, 1, 0);
        step(1, U0, 1, 4, 0, 0, 0, 0, 0, 0, 0, "R7 unpipelined op blocks same unit", 0, 0, 0);
        step(1, UP, 1, 4, 0, 0, 0, 0, 0, 0, 0, "R7 unpipelined op blocks pipe unit", 0, 0, 0);
        step(1, U2, 0, 0, 1, 3, 0, 0, 1, 0, 0, "R7 still blocked in retire cycle", 0, 0, 0);
        step(1, U2, 0, 0, 1, 3, 0, 0, 0, 0, 0, "R2 freed tag 0 reused", 1, 1, 0);
        idle_wb(0);
    endtask

    task automatic t_pipe_full();
        do_flush();
        step(1, UP, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R6 pipe issue 0", 1, 1, 0);
        step(1, UP, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R6 pipe issue 1", 1, 1, 1);
        step(1, UP, 1, 3, 0, 0, 0, 0, 0, 0, 0, "R6 pipe issue 2", 1, 1, 2);
        step(1, UP, 1, 4, 0, 0, 0, 0, 0, 0, 0, "R6 pipe issue 3", 1, 1, 3);
        step(1, UP, 1, 5, 0, 0, 0, 0, 0, 0, 0, "R5 all tags busy", 0, 0, 0);
        step(1, UP, 1, 5, 0, 0, 0, 0, 1, 2, 0, "R5 stall in freeing cycle", 0, 0, 0);
        step(1, UP, 1, 5, 0, 0, 0, 0, 0, 0, 0, "R5 freed tag 2 granted next", 1, 1, 2);
        step(1, U0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 other unit waits for pipe", 0, 0, 0);
        do_flush();
        step(1, U0, 0, 0, 1, 1, 1, 4, 0, 0, 0, "R8 flush cleared pending and tags", 1, 1, 0);
        idle_wb(0);
    endtask

    task automatic t_raw();
        do_flush();
        step(1, UP, 1, 7, 0, 0, 0, 0, 0, 0, 0, "R3 producer issue", 1, 1, 0);
        step(1, UP, 0, 0, 0, 7, 0, 7, 0, 0, 0, "R11 disabled sources ignored", 1, 1, 1);
        step(1, UP, 0, 0, 1, 7, 0, 0, 0, 0, 0, "R3 pending source stalls", 0, 0, 0);
        step(1, UP, 0, 0, 0, 0, 1, 7, 0, 0, 0, "R3 pending second source stalls", 0, 0, 0);
        step(1, UP, 0, 0, 1, 7, 0, 0, 1, 0, 0, "R3 granted in writeback cycle", 1, 1, 2);
        idle_wb(1);
        idle_wb(2);
    endtask

    task automatic t_newest();
        do_flush();
        step(1, UP, 1, 9, 0, 0, 0, 0, 0, 0, 0, "R4 older writer", 1, 1, 0);
        step(1, UP, 1, 9, 0, 0, 0, 0, 0, 0, 0, "R4 newer writer", 1, 1, 1);
        idle_wb(0);
        step(1, UP, 0, 0, 1, 9, 0, 0, 0, 0, 0, "R4 older writeback keeps pending", 0, 0, 0);
        idle_wb(1);
        step(1, UP, 0, 0, 1, 9, 0, 0, 0, 0, 0, "R4 cleared by newest tag", 1, 1, 0);
        step(1, UP, 1, 10, 0, 0, 0, 0, 0, 0, 0, "R10 first writer", 1, 1, 1);
        step(1, UP, 1, 10, 0, 0, 0, 0, 1, 1, 0, "R10 new writer with writeback", 1, 1, 2);
        step(1, UP, 0, 0, 0, 0, 1, 10, 0, 0, 0, "R10 register still pending", 0, 0, 0);
        idle_wb(2);
        step(1, UP, 0, 0, 0, 0, 1, 10, 0, 0, 0, "R10 released by new tag", 1, 1, 1);
        do_flush();
    endtask

    task automatic t_stray();
        do_flush();
        step(1, UP, 1, 12, 0, 0, 0, 0, 0, 0, 0, "R9 producer", 1, 1, 0);
        idle_wb(3);
        step(1, UP, 0, 0, 1, 12, 0, 0, 0, 0, 0, "R9 stray writeback no clear", 0, 0, 0);
        step(1, U2, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 stray writeback no drain", 0, 0, 0);
        idle_wb(0);
        step(1, U2, 0, 0, 1, 12, 0, 0, 0, 0, 0, "R7 other unit after drain", 1, 1, 0);
        idle_wb(0);
    endtask

    initial begin
        rst_n = 1'b0; flush = 1'b0; iss_valid = 1'b0; iss_unit = '0;
        iss_rd_en = 1'b0; iss_ra_en = 1'b0; iss_rb_en = 1'b0;
        iss_rd = '0; iss_ra = '0; iss_rb = '0; wb_valid = 1'b0; wb_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_single();
        t_pipe_full();
        t_raw();
        t_newest();
        t_stray();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule